// File: doc/BRIEF.md
# Timer count-clock edge selector

This block drives the count input of one timer channel. It holds an 8-bit control register that picks one of eight count sources: the base clock, four divided versions of the base clock, two external clock pins, and a strobe from another channel that overflowed or underflowed. The register also picks whether the source counts on its rising edge, its falling edge or both edges. The block turns the chosen source into single-cycle count-enable pulses and feeds them to a 16-bit up-counter. The counter runs while a start input is high.

Edge selection only applies to sources that change slowly enough to have visible edges. For the undivided clock and for the cascade strobe, the block counts one per cycle or one per strobe, whatever the edge field holds. The field still reads back as written. When the phase-counting flag is high, the edge field is ignored and the block counts on rising edges. The phase arithmetic itself is done elsewhere. External pins pass through a synchronizer before edge detection.

Software is expected to rewrite the control register only while the start input is low. Because count pulses are gated by start, a source switch never reaches the counter.

Top module: `tmr_clk_edge_sel`

## Requirements
- R1: The control register resets to 0x00 and reads back all eight written bits unchanged on `ctl_rdata_o`. Field layout: bits 7:5 are the clear select, bits 4:3 the edge select, bits 2:0 the source select. A write completes on the clock edge where `ctl_we_i` is high.
- R2: The source select encodings are:
  - 000: undivided clock
  - 001: `tick_i[0]` (divide-by-4)
  - 010: `tick_i[1]` (divide-by-16)
  - 011: `tick_i[2]` (divide-by-64)
  - 100: `ext_clk_i[0]`
  - 101: `ext_clk_i[1]`
  - 110: `tick_i[3]` (divide-by-256)
  - 111: `casc_ovf_i`

  Activity on any source that is not selected does not change the count.
- R3: The edge select encodings are 00 for the rising edge (0-to-1 of the sampled source), 01 for the falling edge (1-to-0), and 10 or 11 for both edges.
- R4: With both edges selected, each pulse of a prescaled enable yields two counts, where the rising-edge setting yields one. This doubles the effective count rate.
- R5: With source 000 or 111 selected, the edge select has no effect, although it reads back as written. Source 000 counts once for every clock cycle with start high. Source 111 counts once per cycle in which the strobe is high.
- R6: When `phase_mode_i` is high, the edge select is ignored and counting is on rising edges only.
- R7: An external pin passes through a two-flop synchronizer. A pin level that changes before clock edge k produces a one-cycle `cnt_en_o` pulse after edge k+2, when that edge is selected.
- R8: No count-enable pulse is produced and `count_o` holds while `start_i` is low.
- R9: `count_o` wraps from 0xFFFF to 0x0000. `ovf_o` is high for exactly the one cycle in which the wrapped value 0x0000 is first shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register contents |
| start_i | input | 1 | Counter run enable |
| phase_mode_i | input | 1 | Phase-counting mode active, overrides the edge select |
| tick_i | input | 4 | Prescaled enables: divide-by-4, divide-by-16, divide-by-64, divide-by-256 |
| ext_clk_i | input | 2 | Asynchronous external clock pins |
| casc_ovf_i | input | 1 | Overflow/underflow strobe from another channel |
| cnt_en_o | output | 1 | Single-cycle count-enable pulse |
| count_o | output | 16 | Counter value |
| ovf_o | output | 1 | One-cycle wrap strobe |

## Verification
The phase-counting override and the edge select are both present in the same cycle whenever the flag is high and the field holds a non-rising code. The bench provokes this by programming both-edge counting on the divide-by-4 enable with the flag raised. It judges the result by requiring one count per enable pulse instead of two. The wrap and the count pulse also coincide: the bench runs the undivided clock until `ovf_o` appears, and requires the counter to show 0x0000 in that very cycle and 0x0001 with the strobe gone in the next.

// File: rtl/tmr_cs_pkg.sv
`timescale 1ns/1ps
package tmr_cs_pkg;
  localparam int CTL_W = 8;

  typedef enum logic [2:0] {
    SRC_DIV1   = 3'd0,
    SRC_DIV4   = 3'd1,
    SRC_DIV16  = 3'd2,
    SRC_DIV64  = 3'd3,
    SRC_EXT0   = 3'd4,
    SRC_EXT1   = 3'd5,
    SRC_DIV256 = 3'd6,
    SRC_CASC   = 3'd7
  } src_sel_e;

  typedef struct packed {
    logic [2:0] clr_sel;
    logic [1:0] edge_sel;
    src_sel_e   src_sel;
  } ctl_t;
endpackage

// File: rtl/tmr_ext_sync.sv
`timescale 1ns/1ps
module tmr_ext_sync #(
  parameter int N_PIN  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PIN-1:0] pin_i,
  output logic [N_PIN-1:0] pin_o
);
  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '0;
      else         ff_q <= {ff_q[STAGES-2:0], pin_i[p]};
    end
    assign pin_o[p] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/tmr_edge_det.sv
`timescale 1ns/1ps
module tmr_edge_det (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_i,
  input  logic       direct_i,  // level counts as-is
  input  logic [1:0] mode_i,    // 00 rise, 01 fall, 1x both
  output logic       hit_o
);
  logic src_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= 1'b0;
    else         src_q <= src_i;
  end

  assign rise = src_i & ~src_q;
  assign fall = ~src_i & src_q;

  always_comb begin
    if (direct_i)       hit_o = src_i;
    else if (mode_i[1]) hit_o = rise | fall;
    else if (mode_i[0]) hit_o = fall;
    else                hit_o = rise;
  end
endmodule

// File: rtl/tmr_up_cnt.sv
`timescale 1ns/1ps
module tmr_up_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             start_i,
  output logic             cnt_en_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             en_q, ovf_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      en_q  <= hit_i & start_i;
      ovf_q <= en_q && (cnt_q == CNT_MAX);
      if (en_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_en_o = en_q;
  assign count_o  = cnt_q;
  assign ovf_o    = ovf_q;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_o |=> $stable(count_o));
  p_ovf_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (count_o == '0));
  p_ovf_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
endmodule

// File: rtl/tmr_clk_edge_sel.sv
`timescale 1ns/1ps
module tmr_clk_edge_sel
  import tmr_cs_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [7:0]       ctl_wdata_i,
  output logic [7:0]       ctl_rdata_o,
  input  logic             start_i,
  input  logic             phase_mode_i,
  input  logic [3:0]       tick_i,
  input  logic [1:0]       ext_clk_i,
  input  logic             casc_ovf_i,
  output logic             cnt_en_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam int N_EXT = 2;
  localparam int N_SRC = 8;

  ctl_t             ctl_q;
  logic [N_EXT-1:0] ext_s;
  logic [N_SRC-1:0] src_vec;
  logic             src, direct, hit;
  logic [1:0]       eff_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_t'(ctl_wdata_i);
  end
  assign ctl_rdata_o = ctl_q;

  tmr_ext_sync #(.N_PIN(N_EXT), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (ext_clk_i),
    .pin_o (ext_s)
  );

  // index = source select encoding
  assign src_vec = {casc_ovf_i, tick_i[3], ext_s[1], ext_s[0],
                    tick_i[2], tick_i[1], tick_i[0], 1'b1};
  assign src     = src_vec[ctl_q.src_sel];
  assign direct  = (ctl_q.src_sel == SRC_DIV1) || (ctl_q.src_sel == SRC_CASC);
  // fast sources and phase mode fall back to rising edge
  assign eff_mode = (direct || phase_mode_i) ? 2'b00 : ctl_q.edge_sel;

  tmr_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src),
    .direct_i(direct),
    .mode_i  (eff_mode),
    .hit_o   (hit)
  );

  tmr_up_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .start_i (start_i),
    .cnt_en_o(cnt_en_o),
    .count_o (count_o),
    .ovf_o   (ovf_o)
  );

  p_ctl_wr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> (ctl_rdata_o == $past(ctl_wdata_i)));
  p_div1_rate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.src_sel == SRC_DIV1 && start_i) |=> cnt_en_o);
  p_stop_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !cnt_en_o);
endmodule

// File: tb/sim_tmr_clk_edge_sel.sv
`timescale 1ns/1ps
module sim_tmr_clk_edge_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        start = 1'b0;
  logic        phase = 1'b0;
  logic [3:0]  tick = '0;
  logic [1:0]  ext = '0;
  logic        casc = 1'b0;
  logic        cnt_en;
  logic [15:0] count;
  logic        ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_clk_edge_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wdata),
    .ctl_rdata_o(rdata), .start_i(start), .phase_mode_i(phase),
    .tick_i(tick), .ext_clk_i(ext), .casc_ovf_i(casc),
    .cnt_en_o(cnt_en), .count_o(count), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  // ctl = {clr, edge, src}; pulse tick[idx] n times, period 4, return count delta
  task automatic run_tick(input logic [7:0] ctl, input int idx, input int n,
                          input int exp, input string tag);
    logic [15:0] c0, d;
    wr(ctl);
    c0 = count;
    start = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick[idx] = 1'b1;
      @(negedge clk); tick[idx] = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    d = count - c0;
    chk(d == exp, tag, d, exp);
  endtask

  task automatic t_reset;
    chk(rdata == 8'h00, "R1 reset ctl", rdata, 0);
    chk(count == 16'h0, "R9 reset count", count, 0);
    chk(!ovf && !cnt_en, "R8 reset strobes", {ovf, cnt_en}, 0);
  endtask

  task automatic t_regs;
    wr(8'hFF);
    chk(rdata == 8'hFF, "R1 readback FF", rdata, 8'hFF);
    wr(8'hA5);
    chk(rdata == 8'hA5, "R1 readback A5", rdata, 8'hA5);
  endtask

  task automatic t_edges;
    run_tick(8'b000_00_001, 0, 5, 5,  "R3 div4 rising");
    run_tick(8'b000_01_001, 0, 5, 5,  "R3 div4 falling");
    run_tick(8'b000_10_001, 0, 5, 10, "R4 div4 both 10");
    run_tick(8'b000_11_001, 0, 5, 10, "R4 div4 both 11");
    run_tick(8'b000_00_110, 3, 3, 3,  "R2 div256 source");
    run_tick(8'b000_00_010, 0, 4, 0,  "R2 unselected tick ignored");
    run_tick(8'b000_10_011, 2, 3, 6,  "R4 div64 both");
  endtask

  task automatic t_div1;
    logic [15:0] c0, d;
    wr(8'b000_01_000);
    chk(rdata == 8'b000_01_000, "R5 edge field readback", rdata, 8'b000_01_000);
    c0 = count;
    @(negedge clk); start = 1'b1;
    repeat (20) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    d = count - c0;
    chk(d == 20, "R5 div1 one per cycle", d, 20);
  endtask

  task automatic t_casc;
    logic [15:0] c0, d;
    wr(8'b000_10_111);
    c0 = count;
    start = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); casc = 1'b1;
      @(negedge clk); casc = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    d = count - c0;
    chk(d == 4, "R5 cascade ignores both-edge", d, 4);
  endtask

  task automatic t_phase;
    phase = 1'b1;
    run_tick(8'b000_11_001, 0, 5, 5, "R6 phase mode forces rising");
    phase = 1'b0;
  endtask

  task automatic t_ext;
    logic [15:0] c0, d;
    wr(8'b000_00_100);
    c0 = count;
    start = 1'b1;
    @(negedge clk); ext[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); chk(cnt_en == 1'b0, "R7 no pulse before k+2", cnt_en, 0);
    @(negedge clk); chk(cnt_en == 1'b1, "R7 pulse after k+2", cnt_en, 1);
    @(negedge clk); chk(cnt_en == 1'b0, "R7 pulse single cycle", cnt_en, 0);
    repeat (3) @(negedge clk); ext[0] = 1'b0;
    repeat (6) @(negedge clk);
    d = count - c0;
    chk(d == 1, "R7 ext rising only", d, 1);
    wr(8'b000_11_101);
    c0 = count;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ext[1] = 1'b1;
      repeat (4) @(negedge clk); ext[1] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    d = count - c0;
    chk(d == 6, "R7 ext1 both edges", d, 6);
  endtask

  task automatic t_stop;
    logic [15:0] c0;
    bit seen = 1'b0;
    wr(8'b000_00_000);
    c0 = count;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (cnt_en) seen = 1'b1;
    end
    chk(count == c0, "R8 count holds when stopped", count, c0);
    chk(!seen, "R8 no enable when stopped", seen, 0);
  endtask

  task automatic t_wrap;
    wr(8'b000_00_000);
    @(negedge clk); start = 1'b1;
    for (int i = 0; i < 70000 && !ovf; i++) @(negedge clk);
    chk(ovf == 1'b1, "R9 overflow seen", ovf, 1);
    chk(count == 16'h0, "R9 wrap to zero with strobe", count, 0);
    @(negedge clk);
    chk(ovf == 1'b0, "R9 strobe one cycle", ovf, 0);
    chk(count == 16'h1, "R9 count after wrap", count, 1);
    start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_edges();
    t_div1();
    t_casc();
    t_phase();
    t_ext();
    t_stop();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule